// File: doc/BRIEF.md
# Compare-Interrupt Down-Counter Timer

A memory-mapped timer whose counter steps downward, one step for every (prescale + 1) pulses of a timer clock-enable input. A compare match raises a sticky status flag. Software clears the flag by writing 1 to it. The flag drives an interrupt line only when the compare-interrupt enable is set. When the counter passes zero it either reloads from a load register or wraps to all ones. The mode bit decides which.

The usual one-shot sequence is short. Software programs a load value, sets compare to zero and writes the control word with enable and reload-on-enable together. It then waits for the interrupt. A self-clearing software reset returns the control word and the flag to idle. Software polls the busy bit until it drops. Load and compare keep their values through this reset. Fields for power modes, pin output mode and clock source are stored and read back but change nothing.

The bus is a single-cycle write port with a combinational read port. Every address is decoded by the block itself.

Top module: `cmp_down_timer`

## Requirements
- R1: After reset, control reads 0, status reads 0, load reads 0xFFFFFFFF, compare reads 0, the counter reads 0xFFFFFFFF and irq is low.
- R2: The register offsets are control 0x00, status 0x04, load 0x08, compare 0x0C and counter 0x10. Control keeps bits [25:0] and reads bits [31:26] as zero. Status holds the flag at bit 0. Any other offset reads 0.
- R3: While control bit 0 (enable) is set, the counter advances once on every (P+1)-th cycle in which tick is high, where P is control bits [15:4]. Cycles in which tick is low do not count. A non-zero counter steps down by one.
- R4: While enable is clear, the counter holds its value whatever tick does.
- R5: A step from zero loads the load register when control bit 3 is 1. When bit 3 is 0, the same step wraps the counter to 0xFFFFFFFF.
- R6: A control write that changes enable from 0 to 1 with bit 1 set copies the load register into the counter and restarts the prescale count. Without bit 1, enabling leaves the counter unchanged.
- R7: A step whose new counter value equals compare sets the status flag. irq is the flag ANDed with control bit 2.
- R8: Writing status with bit 0 = 1 clears the flag. Writing bit 0 = 0 leaves it unchanged.
- R9: With control bit 17 set, a write to load also writes the counter in the same cycle. With bit 17 clear, the counter is untouched.
- R10: A control write with bit 16 set clears every other control bit and the flag. Load and compare are left unchanged. Bit 16 then reads 1 for SWR_CYCLES clock cycles and clears itself. Control and status writes made during that window are ignored.
- R11: Writes to the counter offset are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock-enable pulse |
| wrEn | input | 1 | Write strobe, one write per cycle |
| addr | input | 5 | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for addr |
| irq | output | 1 | Compare interrupt request |

## Verification
The assertions assume that a bus write lasts exactly one cycle. The properties for a stable counter and for decrement also assume that no write lands in the cycle they look at, so their antecedents exclude cycles with wrEn high. Flag-clearing is checked only on cycles with no compare match, because a match in that same cycle takes priority. The stimulus moves the bus and tick only on falling edges and keeps tick low during every register access. The prescale and reload sweeps therefore see an exact, predictable number of qualifying ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W  = 5;
  localparam int CTRL_W  = 26;
  localparam int PSC_W   = 12;

  localparam logic [ADDR_W-1:0] OFF_CTRL   = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_LOAD   = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_CMP    = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_COUNT  = 5'h10;

  // control field positions (software-visible)
  localparam int B_EN     = 0;
  localparam int B_ENLOAD = 1;
  localparam int B_IRQEN  = 2;
  localparam int B_RELOAD = 3;
  localparam int B_PSC_LO = 4;
  localparam int B_SWR    = 16;
  localparam int B_OVWR   = 17;

  // strobes from control to datapath
  typedef struct packed {
    logic loadFromReg;
    logic writeData;
    logic step;
  } cntStrb_t;
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrb_t         strb,
  input  logic             reloadMode,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] cmpVal,
  input  logic [CNT_W-1:0] wrVal,
  output logic [CNT_W-1:0] count,
  output logic             matchHit
);
  logic [CNT_W-1:0] nextStep;
  logic             atZero;

  assign atZero = (count == '0);

  always_comb begin
    if (atZero) nextStep = reloadMode ? loadVal : '1;
    else        nextStep = count - 1'b1;
  end

  // bus overwrite beats enable-load beats counting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 count <= '1;
    else if (strb.writeData)   count <= wrVal;
    else if (strb.loadFromReg) count <= loadVal;
    else if (strb.step)        count <= nextStep;
  end

  assign matchHit = strb.step && !strb.writeData && (nextStep == cmpVal);
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int SWR_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  input  logic              matchHit,
  output logic [CTRL_W-1:0] ctrlReg,
  output logic              statFlag,
  output logic [CNT_W-1:0]  loadReg,
  output logic [CNT_W-1:0]  cmpReg,
  output cntStrb_t          strb
);
  localparam int SWR_W = $clog2(SWR_CYCLES + 1);

  logic             swrBusy;
  logic [SWR_W-1:0] swrCnt;
  logic [PSC_W-1:0] psCnt;
  logic [PSC_W-1:0] pscVal;
  logic             wrCtrl, wrStat, wrLoad, wrCmp;
  logic             swrReq, swrDone, enabled, stepNow;

  assign swrBusy = ctrlReg[B_SWR];
  assign enabled = ctrlReg[B_EN];
  assign pscVal  = ctrlReg[B_PSC_LO +: PSC_W];

  assign wrCtrl = wrEn && (addr == OFF_CTRL)   && !swrBusy;
  assign wrStat = wrEn && (addr == OFF_STATUS) && !swrBusy;
  assign wrLoad = wrEn && (addr == OFF_LOAD);
  assign wrCmp  = wrEn && (addr == OFF_CMP);
  assign swrReq = wrCtrl && wrData[B_SWR];
  assign swrDone = swrBusy && (swrCnt == '0);

  // control register with self-clearing reset bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (swrReq) begin
      ctrlReg <= '0;
      ctrlReg[B_SWR] <= 1'b1;
    end else if (wrCtrl) begin
      ctrlReg <= wrData[CTRL_W-1:0];
    end else if (swrDone) begin
      ctrlReg[B_SWR] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     swrCnt <= '0;
    else if (swrReq)               swrCnt <= SWR_W'(SWR_CYCLES - 1);
    else if (swrBusy && !swrDone)  swrCnt <= swrCnt - 1'b1;
  end

  // sticky compare flag, write-one-to-clear; a match beats a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      statFlag <= 1'b0;
    else if (swrReq || swrBusy)     statFlag <= 1'b0;
    else if (matchHit)              statFlag <= 1'b1;
    else if (wrStat && wrData[0])   statFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadReg <= '1;
      cmpReg  <= '0;
    end else begin
      if (wrLoad) loadReg <= wrData[CNT_W-1:0];
      if (wrCmp)  cmpReg  <= wrData[CNT_W-1:0];
    end
  end

  // prescaler: restart whenever the timer is off
  assign stepNow = enabled && tick && (psCnt >= pscVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        psCnt <= '0;
    else if (!enabled) psCnt <= '0;
    else if (tick)     psCnt <= (psCnt >= pscVal) ? '0 : psCnt + 1'b1;
  end

  always_comb begin
    strb.step        = stepNow;
    strb.writeData   = wrLoad && ctrlReg[B_OVWR];
    strb.loadFromReg = wrCtrl && !wrData[B_SWR] && !enabled &&
                       wrData[B_EN] && wrData[B_ENLOAD];
  end
endmodule

// File: rtl/cmp_down_timer.sv
module cmp_down_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int SWR_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        wrEn,
  input  logic [4:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        irq
);
  logic [CTRL_W-1:0] ctrlReg;
  logic              statFlag;
  logic [CNT_W-1:0]  loadReg, cmpReg, count;
  logic              matchHit;
  cntStrb_t          strb;

  tmr_ctrl #(.CNT_W(CNT_W), .SWR_CYCLES(SWR_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .matchHit(matchHit), .ctrlReg(ctrlReg),
    .statFlag(statFlag), .loadReg(loadReg), .cmpReg(cmpReg), .strb(strb)
  );

  tmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reloadMode(ctrlReg[B_RELOAD]),
    .loadVal(loadReg), .cmpVal(cmpReg), .wrVal(wrData[CNT_W-1:0]),
    .count(count), .matchHit(matchHit)
  );

  always_comb begin
    case (addr)
      OFF_CTRL:   rdData = 32'(ctrlReg);
      OFF_STATUS: rdData = {31'b0, statFlag};
      OFF_LOAD:   rdData = 32'(loadReg);
      OFF_CMP:    rdData = 32'(cmpReg);
      OFF_COUNT:  rdData = 32'(count);
      default:    rdData = '0;
    endcase
  end

  assign irq = statFlag & ctrlReg[B_IRQEN];
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [4:0]        addr,
  input logic [31:0]       wrData,
  input logic [CTRL_W-1:0] ctrlReg,
  input logic              flag,
  input logic [CNT_W-1:0]  count,
  input cntStrb_t          strb,
  input logic              matchHit,
  input logic              irq
);
  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !wrEn && count != '0) |=> count == $past(count) - 1'b1);

  assert_hold_disabled_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlReg[B_EN] && !wrEn) |=> $stable(count));

  assert_rollover_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !wrEn && count == '0 && !ctrlReg[B_RELOAD]) |=> (&count));

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (ctrlReg[B_IRQEN] && flag));

  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFF_STATUS && wrData[0] && !matchHit) |=> !flag);

  assert_overwrite_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFF_LOAD && ctrlReg[B_OVWR]) |=> count == $past(wrData[CNT_W-1:0]));

  assert_swr_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg[B_SWR] |-> (ctrlReg[15:0] == '0 && ctrlReg[CTRL_W-1:17] == '0 && !flag));
endmodule

bind cmp_down_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .ctrlReg(ctrlReg), .flag(statFlag), .count(count), .strb(strb),
  .matchHit(matchHit), .irq(irq)
);

// File: tb/tb_cmp_down_timer.sv
`timescale 1ns/1ps
module tb_cmp_down_timer;
  localparam int SWR_CYCLES = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cmp_down_timer #(.CNT_W(32), .SWR_CYCLES(SWR_CYCLES)) dut (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic doTicks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  // arithmetic model: {flag, count} after a number of steps
  function automatic logic [32:0] model(input logic [31:0] ld, input logic [31:0] cmp,
                                        input int steps, input bit rld);
    logic [31:0] c = ld;
    logic f = 1'b0;
    for (int i = 0; i < steps; i++) begin
      if (c == 0) c = rld ? ld : 32'hFFFF_FFFF;
      else        c = c - 1;
      if (c == cmp) f = 1'b1;
    end
    return {f, c};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    logic [32:0] m;
    int polls;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRd(5'h00, v); chk("R1 ctrl", v, 32'h0);
    busRd(5'h04, v); chk("R1 status", v, 32'h0);
    busRd(5'h08, v); chk("R1 load", v, 32'hFFFF_FFFF);
    busRd(5'h0C, v); chk("R1 compare", v, 32'h0);
    busRd(5'h10, v); chk("R1 counter", v, 32'hFFFF_FFFF);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 map and masking
    busWr(5'h00, 32'hFFFE_FFF4);
    busRd(5'h00, v); chk("R2 ctrl mask", v, 32'h03FE_FFF4);
    busWr(5'h00, 32'h0);
    busWr(5'h08, 32'h1234_5678);
    busRd(5'h08, v); chk("R2 load readback", v, 32'h1234_5678);
    busRd(5'h10, v); chk("R9 no overwrite", v, 32'hFFFF_FFFF);
    busWr(5'h0C, 32'hA5A5_0003);
    busRd(5'h0C, v); chk("R2 compare readback", v, 32'hA5A5_0003);
    busRd(5'h14, v); chk("R2 unmapped", v, 32'h0);

    // R11 counter is read-only
    busWr(5'h10, 32'h0);
    busRd(5'h10, v); chk("R11 counter write ignored", v, 32'hFFFF_FFFF);

    // R9 overwrite
    busWr(5'h00, 32'h0002_0000);
    busWr(5'h08, 32'h0000_0055);
    busRd(5'h10, v); chk("R9 overwrite counter", v, 32'h55);

    // R6 enable without and with reload
    busWr(5'h00, 32'h1);
    busRd(5'h10, v); chk("R6 plain enable keeps counter", v, 32'h55);
    busWr(5'h00, 32'h0);
    busWr(5'h08, 32'h7);
    busWr(5'h00, 32'h3);
    busRd(5'h10, v); chk("R6 enable loads counter", v, 32'h7);
    busWr(5'h00, 32'h0);

    // R4 disabled holds
    doTicks(5);
    busRd(5'h10, v); chk("R4 disabled hold", v, 32'h7);

    // R3 R5 R7 sweep: prescale 0..3, both modes, 0..12 ticks
    for (int p = 0; p < 4; p++) begin
      for (int rld = 0; rld < 2; rld++) begin
        for (int k = 0; k <= 12; k++) begin
          busWr(5'h00, 32'h0);
          busWr(5'h04, 32'h1);
          busWr(5'h08, 32'h3);
          busWr(5'h0C, 32'h1);
          busWr(5'h00, 32'h7 | (32'(rld) << 3) | (32'(p) << 4));
          doTicks(k);
          m = model(32'h3, 32'h1, k / (p + 1), rld[0]);
          busRd(5'h10, v); chk(rld ? "R3 R5 reload count" : "R3 R5 wrap count", v, m[31:0]);
          busRd(5'h04, v); chk("R7 flag", v, {31'b0, m[32]});
          chk("R7 irq", {31'b0, irq}, {31'b0, m[32]});
        end
      end
    end

    // R7 interrupt enable gates irq
    busWr(5'h00, 32'h0);
    busWr(5'h04, 32'h1);
    busWr(5'h08, 32'h2);
    busWr(5'h0C, 32'h0);
    busWr(5'h00, 32'h3);
    doTicks(2);
    busRd(5'h04, v); chk("R7 flag set without irq enable", v, 32'h1);
    chk("R7 irq masked", {31'b0, irq}, 32'h0);

    // R8 write-one-to-clear
    busWr(5'h00, 32'h0);
    busWr(5'h04, 32'h0);
    busRd(5'h04, v); chk("R8 write zero keeps flag", v, 32'h1);
    busWr(5'h04, 32'h1);
    busRd(5'h04, v); chk("R8 write one clears flag", v, 32'h0);

    // R10 software reset: set flag first
    busWr(5'h08, 32'h2);
    busWr(5'h00, 32'h7);
    doTicks(2);
    busRd(5'h04, v); chk("R10 precondition flag", v, 32'h1);
    busWr(5'h00, 32'h0001_0007);
    polls = 0;
    for (int i = 0; i < 20; i++) begin
      busRd(5'h00, v);
      if (v[16]) polls++;
      else break;
    end
    // write lands at edge E0; reads follow E1, E2 (busy) and E3 (clear)
    chk("R10 busy window", 32'(polls), 32'(SWR_CYCLES - 1));
    busRd(5'h00, v); chk("R10 ctrl cleared", v, 32'h0);
    busRd(5'h04, v); chk("R10 flag cleared", v, 32'h0);
    busRd(5'h08, v); chk("R10 load kept", v, 32'h2);
    busRd(5'h0C, v); chk("R10 compare kept", v, 32'h0);
    busWr(5'h00, 32'h0001_0000);
    busWr(5'h00, 32'h0000_0004);
    repeat (SWR_CYCLES + 2) @(negedge clk);
    busRd(5'h00, v); chk("R10 ctrl write ignored while busy", v, 32'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule